// File: doc/BRIEF.md
# LCD Scan Timing Generator with Status Word

This block produces the horizontal and vertical scan position of a 240x160 display. A pixel-rate enable drives it. A dot counter runs across each line and a line counter runs down each frame. From these two counters the block derives horizontal-blank and vertical-blank flags, and it shows both on output pins.

A line-compare flag stays high for as long as the current line equals a line number that software has programmed. Three interrupt request outputs each give a pulse one clock cycle long: on entry to vertical blank, on entry to horizontal blank, and when the compare flag goes high. Each of the three has its own enable bit.

A small register port has two registers. Software writes the compare line and the three enables through the status word, and reads back the status word and the current line number. Read data is registered.

Top module: `lcd_scan_timer`

## Requirements
- R1: The dot counter counts 0 to H_TOTAL-1 (default 308) and then returns to 0. The hblank output and status bit 1 are high for dots H_ACTIVE (default 240) through H_TOTAL-1 and low on every other dot.
- R2: The line counter counts 0 to V_TOTAL-1 (default 228). It advances when the dot counter returns to 0 and then returns to 0 itself. The vblank output and status bit 0 are high on lines V_ACTIVE (default 160) and above. Register select 1 reads the line number in bits 7:0, with zeros in bits 15:8.
- R3: Both counters hold their value on any clock cycle in which dot_en is low.
- R4: Register select 0 reads the status word. It is laid out as {compare[15:8], 2'b00, line-compare enable[5], hblank enable[4], vblank enable[3], compare flag[2], hblank[1], vblank[0]}. reg_rdata is 0x0000 while reset is held, and the compare setting and all enables reset to 0.
- R5: Status bit 2 is high exactly while the current line equals the compare setting. It drops by itself as soon as the two differ.
- R6: A write to the status word stores only bits 15:8 and bits 5:3. Write data in bits 2:0 has no effect on the flags. A write with select 1 changes nothing.
- R7: irq_vblank pulses for one cycle when the line counter enters line V_ACTIVE, provided status bit 3 is set.
- R8: irq_hblank pulses for one cycle when the dot counter reaches H_ACTIVE on any line, provided status bit 4 is set.
- R9: irq_line pulses for one cycle when the compare flag goes from low to high, provided status bit 5 is set.
- R10: After a write to the compare setting, the compare flag takes the value for the new setting on the clock edge that performs the write.
- R11: reg_rdata is registered. It shows the selected register as that register stood before the clock edge that loads reg_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Pixel-rate enable; advances the dot position |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the line number |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| vblank | output | 1 | High during vertical blank lines |
| hblank | output | 1 | High during horizontal blank dots |
| irq_vblank | output | 1 | One-cycle pulse on entry to vertical blank |
| irq_hblank | output | 1 | One-cycle pulse on entry to horizontal blank |
| irq_line | output | 1 | One-cycle pulse when the compare flag rises |

## Verification
The bench builds the block with a reduced raster: 8 active dots in a 12-dot line and 6 active lines in a 9-line frame. With this raster a whole frame lasts about a hundred enables, so each run reaches both counter wraps, the vblank entry and several compare matches. Gaps in the pixel enable show that the counters hold their value. Compare writes, both to a line that matches the current line and to one that does not, are placed at chosen raster positions. This exposes the re-evaluation at the write edge and the way the compare flag rises at the start of a matching line.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int FIELD_W = 8;   // width of line number and compare field
  localparam int WORD_W  = 16;
  localparam int NUM_IRQ = 3;
  // interrupt/enable index; also the order of enable bits 3..5
  localparam int IRQ_VB  = 0;
  localparam int IRQ_HB  = 1;
  localparam int IRQ_LN  = 2;
  localparam int EN_LSB  = 3;
  localparam int CMP_LSB = 8;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_LINE   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/lcd_scan_counter.sv
module lcd_scan_counter #(
  parameter int H_ACTIVE = 240,
  parameter int H_TOTAL  = 308,
  parameter int V_ACTIVE = 160,
  parameter int V_TOTAL  = 228,
  parameter int DOT_W    = 9,
  parameter int LINE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dot_en,
  output logic [DOT_W-1:0]  dot_q,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_nxt,
  output logic              hblank_q,
  output logic              vblank_q,
  output logic              h_evt,
  output logic              v_evt
);
  logic [DOT_W-1:0] dot_nxt;
  logic dot_last, line_last;

  always_comb begin
    dot_last  = (dot_q == DOT_W'(H_TOTAL - 1));
    line_last = (line_q == LINE_W'(V_TOTAL - 1));
    dot_nxt   = dot_q;
    line_nxt  = line_q;
    if (dot_en) begin
      dot_nxt = dot_last ? '0 : dot_q + 1'b1;
      if (dot_last) line_nxt = line_last ? '0 : line_q + 1'b1;
    end
    h_evt = dot_en && (dot_q == DOT_W'(H_ACTIVE - 1));
    v_evt = dot_en && dot_last && (line_q == LINE_W'(V_ACTIVE - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q    <= '0;
      line_q   <= '0;
      hblank_q <= 1'b0;
      vblank_q <= 1'b0;
    end else begin
      dot_q    <= dot_nxt;
      line_q   <= line_nxt;
      hblank_q <= (dot_nxt >= DOT_W'(H_ACTIVE));
      vblank_q <= (line_nxt >= LINE_W'(V_ACTIVE));
    end
  end
endmodule

// File: rtl/lcd_line_match.sv
module lcd_line_match #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] line_nxt,
  input  logic [LINE_W-1:0] cmp_nxt,
  output logic              match_q,
  output logic              rise_evt
);
  logic match_d;

  always_comb begin
    match_d  = (line_nxt == cmp_nxt);
    rise_evt = match_d && !match_q;
  end

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= match_d;
  end
endmodule

// File: rtl/lcd_irq_pulse.sv
module lcd_irq_pulse #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  output logic [N-1:0] irq_q
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) irq_q[i] <= 1'b0;
      else     irq_q[i] <= evt[i] & en[i];
    end
  end
endmodule

// File: rtl/lcd_scan_regs.sv
module lcd_scan_regs
  import lcd_scan_pkg::*;
#(
  parameter int LINE_W = FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic              vblank_q,
  input  logic              hblank_q,
  input  logic              match_q,
  input  logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] cmp_q,
  output logic [LINE_W-1:0] cmp_nxt,
  output logic [NUM_IRQ-1:0] en_q,
  output logic [WORD_W-1:0] rdata
);
  logic wr_hit;
  logic [NUM_IRQ-1:0] en_nxt;
  logic [WORD_W-1:0] status_w, line_w;

  always_comb begin
    wr_hit  = wr && (reg_sel_e'(sel) == SEL_STATUS);
    cmp_nxt = wr_hit ? wdata[CMP_LSB +: LINE_W] : cmp_q;
    en_nxt  = wr_hit ? wdata[EN_LSB +: NUM_IRQ] : en_q;
    status_w = {cmp_q, 2'b00, en_q, match_q, hblank_q, vblank_q};
    line_w   = {{(WORD_W-LINE_W){1'b0}}, line_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      en_q  <= '0;
      rdata <= '0;
    end else begin
      cmp_q <= cmp_nxt;
      en_q  <= en_nxt;
      rdata <= (reg_sel_e'(sel) == SEL_LINE) ? line_w : status_w;
    end
  end
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int H_ACTIVE = 240,
  parameter int H_TOTAL  = 308,
  parameter int V_ACTIVE = 160,
  parameter int V_TOTAL  = 228
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dot_en,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        vblank,
  output logic        hblank,
  output logic        irq_vblank,
  output logic        irq_hblank,
  output logic        irq_line
);
  localparam int DOT_W  = $clog2(H_TOTAL);
  localparam int LINE_W = FIELD_W;

  logic [DOT_W-1:0]   dot_q;
  logic [LINE_W-1:0]  line_q, line_nxt, cmp_q, cmp_nxt;
  logic               hblank_q, vblank_q, h_evt, v_evt, match_q, rise_evt;
  logic [NUM_IRQ-1:0] en_q, evt, irq_q;

  lcd_scan_counter #(
    .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL),
    .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) cnt_i (
    .clk(clk), .rst(rst), .dot_en(dot_en),
    .dot_q(dot_q), .line_q(line_q), .line_nxt(line_nxt),
    .hblank_q(hblank_q), .vblank_q(vblank_q),
    .h_evt(h_evt), .v_evt(v_evt)
  );

  lcd_scan_regs #(.LINE_W(LINE_W)) regs_i (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .vblank_q(vblank_q), .hblank_q(hblank_q), .match_q(match_q),
    .line_q(line_q), .cmp_q(cmp_q), .cmp_nxt(cmp_nxt), .en_q(en_q),
    .rdata(reg_rdata)
  );

  lcd_line_match #(.LINE_W(LINE_W)) match_i (
    .clk(clk), .rst(rst), .line_nxt(line_nxt), .cmp_nxt(cmp_nxt),
    .match_q(match_q), .rise_evt(rise_evt)
  );

  always_comb begin
    evt         = '0;
    evt[IRQ_VB] = v_evt;
    evt[IRQ_HB] = h_evt;
    evt[IRQ_LN] = rise_evt;
  end

  lcd_irq_pulse #(.N(NUM_IRQ)) irq_i (
    .clk(clk), .rst(rst), .evt(evt), .en(en_q), .irq_q(irq_q)
  );

  assign vblank     = vblank_q;
  assign hblank     = hblank_q;
  assign irq_vblank = irq_q[IRQ_VB];
  assign irq_hblank = irq_q[IRQ_HB];
  assign irq_line   = irq_q[IRQ_LN];
endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk #(
  parameter int H_ACTIVE = 240,
  parameter int H_TOTAL  = 308,
  parameter int V_ACTIVE = 160,
  parameter int V_TOTAL  = 228,
  parameter int DOT_W    = 9,
  parameter int LINE_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dot_en,
  input logic [DOT_W-1:0]  dot_q,
  input logic [LINE_W-1:0] line_q,
  input logic [LINE_W-1:0] cmp_q,
  input logic              match_q,
  input logic              hblank,
  input logic              vblank,
  input logic              irq_vblank,
  input logic              irq_hblank,
  input logic              irq_line
);
  a_r1_dot_range: assert property (@(posedge clk) disable iff (rst)
    32'(dot_q) < H_TOTAL);
  a_r2_line_range: assert property (@(posedge clk) disable iff (rst)
    32'(line_q) < V_TOTAL);
  a_r3_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    !dot_en |=> ($stable(dot_q) && $stable(line_q)));
  a_r5_live_compare: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (match_q == (line_q == cmp_q)));
  a_r7_vblank_irq_entry: assert property (@(posedge clk) disable iff (rst)
    irq_vblank |-> (vblank && 32'(line_q) == V_ACTIVE && dot_q == '0));
  a_r8_hblank_irq_entry: assert property (@(posedge clk) disable iff (rst)
    irq_hblank |-> (hblank && 32'(dot_q) == H_ACTIVE));
  a_r9_line_irq_rise: assert property (@(posedge clk) disable iff (rst)
    irq_line |-> (match_q && !$past(match_q)));
  a_r8_r7_never_together: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_vblank, irq_hblank}));
endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(
  .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL),
  .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
  .DOT_W(DOT_W), .LINE_W(LINE_W)
) chk_i (
  .clk(clk), .rst(rst), .dot_en(dot_en), .dot_q(dot_q), .line_q(line_q),
  .cmp_q(cmp_q), .match_q(match_q), .hblank(hblank), .vblank(vblank),
  .irq_vblank(irq_vblank), .irq_hblank(irq_hblank), .irq_line(irq_line)
);

// File: tb/lcd_scan_timer_tb_top.sv
module lcd_scan_timer_tb_top;
  localparam int HA = 8, HT = 12, VA = 6, VT = 9;

  logic clk = 1'b0, rst = 1'b1, dot_en = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic vblank, hblank, irq_vblank, irq_hblank, irq_line;

  int total = 0, bad = 0;
  int mdot = 0, mline = 0, pdot = 0, pline = 0;
  logic [2:0] men = '0;
  logic [7:0] mcmp = '0;

  always #5 clk = ~clk;

  lcd_scan_timer #(.H_ACTIVE(HA), .H_TOTAL(HT), .V_ACTIVE(VA), .V_TOTAL(VT)) dut_i (
    .clk(clk), .rst(rst), .dot_en(dot_en), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vblank(vblank), .hblank(hblank),
    .irq_vblank(irq_vblank), .irq_hblank(irq_hblank), .irq_line(irq_line)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int stat_exp();
    return {16'(mcmp) << 8} | (int'(men) << 3) | ((mline == int'(mcmp)) ? 4 : 0)
           | ((mdot >= HA) ? 2 : 0) | ((mline >= VA) ? 1 : 0);
  endfunction

  // one clock: drive at negedge, update bench model after the edge
  task automatic tick(input logic en, input logic wr = 1'b0, input logic sel = 1'b0,
                      input logic [15:0] data = '0);
    @(negedge clk);
    dot_en = en; reg_wr = wr; reg_sel = sel; reg_wdata = data;
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    pdot = mdot; pline = mline;
    if (en) begin
      if (mdot == HT - 1) begin
        mdot = 0;
        mline = (mline == VT - 1) ? 0 : mline + 1;
      end else mdot++;
    end
    if (wr && !sel) begin men = data[5:3]; mcmp = data[15:8]; end
  endtask

  task automatic read_reg(input logic sel, output int val);
    tick(1'b0, 1'b0, sel);
    tick(1'b0, 1'b0, sel);
    val = int'(reg_rdata);
  endtask

  task automatic t_reset;
    chk("R4 reset rdata", int'(reg_rdata), 0);
    chk("R4 reset irqs", int'({irq_vblank, irq_hblank, irq_line}), 0);
  endtask

  task automatic t_idle;
    int v;
    for (int i = 0; i < 20; i++) tick(1'b0);
    read_reg(1'b1, v);
    chk("R3 line held without enable", v, 0);
    read_reg(1'b0, v);
    chk("R5 status at line 0 with compare 0", v, 16'h0004);
  endtask

  // scan with gaps in the enable, checking flags and irqs every cycle
  task automatic t_scan(input string tag, input int n);
    int eh = 0, ev = 0, el = 0, bh = 0, bv = 0, ph = 0, pv = 0, pl = 0, v;
    for (int i = 0; i < n; i++) begin
      logic en = (i % 4) != 3;
      logic xh, xv, xl;
      tick(en);
      xh = en && men[1] && pdot == HA - 1;
      xv = en && men[0] && pdot == HT - 1 && mline == VA;
      xl = men[2] && mline == int'(mcmp) && pline != int'(mcmp);
      if (hblank !== (mdot >= HA)) bh++;
      if (vblank !== (mline >= VA)) bv++;
      if (irq_hblank !== xh) eh++;
      if (irq_vblank !== xv) ev++;
      if (irq_line !== xl) el++;
      ph += int'(xh); pv += int'(xv); pl += int'(xl);
    end
    chk({tag, " R1 hblank per dot mismatches"}, bh, 0);
    chk({tag, " R2 vblank per line mismatches"}, bv, 0);
    chk({tag, " R8 hblank irq mismatches"}, eh, 0);
    chk({tag, " R7 vblank irq mismatches"}, ev, 0);
    chk({tag, " R9 line irq mismatches"}, el, 0);
    if (men == 3'b111) chk({tag, " R7 R8 R9 pulses seen"}, int'(ph > 0 && pv > 0 && pl > 0), 1);
    read_reg(1'b1, v);
    chk({tag, " R2 line register"}, v, mline);
  endtask

  task automatic t_write_ignore;
    int v, l;
    while (mdot >= HA || mline >= VA || mline == 3) tick(1'b1);
    tick(1'b0, 1'b1, 1'b0, 16'h0307);
    read_reg(1'b0, v);
    chk("R6 low write bits ignored", v, stat_exp());
    chk("R4 R6 field check no flags", v & 7, 0);
    read_reg(1'b1, l);
    tick(1'b0, 1'b1, 1'b1, 16'h00AA);
    read_reg(1'b1, v);
    chk("R6 line register not writable", v, l);
    read_reg(1'b0, v);
    chk("R6 status unchanged by line write", v, stat_exp());
  endtask

  task automatic t_compare_write;
    int v;
    tick(1'b0, 1'b1, 1'b0, 16'((((mline + 1) % VT) << 8) | 16'h20));
    read_reg(1'b0, v);
    chk("R5 no match on other line", (v >> 2) & 1, 0);
    tick(1'b0, 1'b1, 1'b0, 16'((mline << 8) | 16'h20));
    chk("R10 R9 irq on compare write edge", int'(irq_line), 1);
    tick(1'b0);
    chk("R9 line irq single cycle", int'(irq_line), 0);
    read_reg(1'b0, v);
    chk("R10 flag after compare write", (v >> 2) & 1, 1);
    while (mline == int'(mcmp)) tick(1'b1);
    read_reg(1'b0, v);
    chk("R5 flag clears when line moves on", (v >> 2) & 1, 0);
  endtask

  task automatic t_read_lag;
    while (mdot != HT - 1) tick(1'b1);
    tick(1'b1, 1'b0, 1'b1);
    chk("R11 rdata shows line before edge", int'(reg_rdata), pline);
    tick(1'b0, 1'b0, 1'b1);
    chk("R11 rdata catches up", int'(reg_rdata), mline);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_scan("off", 150);
    tick(1'b0, 1'b1, 1'b0, 16'h0338);
    t_scan("on", 160);
    t_write_ignore();
    t_compare_write();
    t_read_lag();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule